// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block is the interrupt and status section of a real-time clock. It keeps three event flags: periodic, alarm and update-ended. Single-cycle pulses from the timekeeping core set these flags. Each flag has an enable bit, and the enable register also holds a square-wave output enable. A summary request bit reports whether any enabled flag is pending. That bit drives an open-drain, active-low interrupt line, which is modelled here as an output-enable signal (`irq_oe` high means the pad pulls low; low means the pad floats).

Software writes the enable register through a write strobe and reads the flag register through a read strobe. A read returns the current flags and clears them on the following clock edge, which releases the interrupt line. An active-low external reset clears all enables and flags and floats the line. It does not touch any timekeeping state, because that state lives outside this block.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A pulse on `evt_per`, `evt_alm` or `evt_upd` sets the matching flag at the next rising clock edge, whether or not that flag's enable is set.
- R2: `irq_oe` is high exactly when at least one flag is set together with its enable bit. Otherwise it is low, so the line floats.
- R3: The flag read data `flag_rdata` is laid out as follows: bit 7 is the summary request (equal to `irq_oe`), bit 6 is the periodic flag, bit 5 is the alarm flag, bit 4 is the update-ended flag, and bits 3:0 are zero.
- R4: A cycle with `flag_re` high presents the current flags on `flag_rdata` and clears all three flags at the next edge. With no new event, `irq_oe` is then low.
- R5: An event pulse in the same cycle as `flag_re` leaves that flag set after the edge, so the event is not lost.
- R6: A write through `en_we` takes `en_wdata` at the next edge. If the write sets an enable whose flag is already pending, `irq_oe` rises in that next cycle.
- R7: While `rst_n` is low, all enables, the square-wave enable, all flags and the summary are zero and `irq_oe` is low, without waiting for a clock edge.
- R8: The enable register is laid out as follows: bit 0 enables periodic, bit 1 enables alarm, bit 2 enables update-ended, and bit 3 is the square-wave output enable. It reads back on `en_q`, and `sqw_en` follows bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of interrupt state |
| evt_per | input | 1 | Periodic event pulse |
| evt_alm | input | 1 | Alarm event pulse |
| evt_upd | input | 1 | Update-ended event pulse |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable register write data |
| flag_re | input | 1 | Flag register read strobe (clear on read) |
| en_q | output | 4 | Enable register contents |
| sqw_en | output | 1 | Square-wave output enable |
| flag_rdata | output | 8 | Flag register read data |
| irq_oe | output | 1 | Drive-low enable for the open-drain interrupt line |

## Verification
A corrupted flag bit shows at once on `flag_rdata`. If that flag's enable is set, it also shows on `irq_oe` in the same cycle, because both outputs are combinational views of the flag and enable registers. A clear-on-read that drops a coincident event appears as a missing flag in the cycle after the read. A wrong enable shows on `en_q` one cycle after the write. The bench keeps a cycle-level model of flags and enables and compares every output on every cycle, so a divergence is reported within one cycle of its cause.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_per,
  input  logic       evt_alm,
  input  logic       evt_upd,
  input  logic       en_we,
  input  logic [3:0] en_wdata,
  input  logic       flag_re,
  output logic [3:0] en_q,
  output logic       sqw_en,
  output logic [7:0] flag_rdata,
  output logic       irq_oe
);
  logic [2:0] flg_q;
  logic [3:0] en_r;
  logic [2:0] evt;
  logic       pend;

  assign evt = {evt_upd, evt_alm, evt_per};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= 3'b000;
      en_r  <= 4'b0000;
    end else begin
      if (en_we) en_r <= en_wdata;
      flg_q <= (flag_re ? 3'b000 : flg_q) | evt;
    end
  end

  assign pend       = |(flg_q & en_r[2:0]);
  assign irq_oe     = pend;
  assign en_q       = en_r;
  assign sqw_en     = en_r[3];
  assign flag_rdata = {pend, flg_q[0], flg_q[1], flg_q[2], 4'b0000};

  p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flg_q & $past(evt)) == $past(evt)));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe && !(|evt) && !en_we) |=> !irq_oe);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_re && !(|evt)) |=> (flag_rdata[6:4] == 3'b000 && !irq_oe));

  p_keep_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_re && evt_alm) |=> flag_rdata[5]);

  p_write_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !flag_re && (|(flg_q & en_wdata[2:0]))) |=> irq_oe);

  p_sqw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (sqw_en == $past(en_wdata[3])));
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_per = 0, evt_alm = 0, evt_upd = 0, en_we = 0, flag_re = 0;
  logic [3:0] en_wdata = 4'b0;
  logic [3:0] en_q;
  logic sqw_en, irq_oe;
  logic [7:0] flag_rdata;

  int n_tests = 0, n_fail = 0;
  logic [2:0] m_flg = 3'b0;
  logic [3:0] m_en = 4'b0;

  always #4 clk = ~clk;

  rtc_irq_ctrl u_rtc_irq_ctrl (.*);

  function automatic logic exp_irq(logic [2:0] f, logic [3:0] e);
    return |(f & e[2:0]);
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] f, logic [3:0] e);
    return {exp_irq(f, e), f[0], f[1], f[2], 4'b0000};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R2 irq"}, {31'b0, irq_oe}, {31'b0, exp_irq(m_flg, m_en)});
    chk({tag, " R3 rdata"}, {24'b0, flag_rdata}, {24'b0, exp_rd(m_flg, m_en)});
    chk({tag, " R8 en"}, {28'b0, en_q}, {28'b0, m_en});
    chk({tag, " R8 sqw"}, {31'b0, sqw_en}, {31'b0, m_en[3]});
  endtask

  task automatic step(logic p, logic a, logic u, logic we, logic [3:0] wd, logic re);
    @(negedge clk);
    evt_per = p; evt_alm = a; evt_upd = u; en_we = we; en_wdata = wd; flag_re = re;
    if (re) chk("R4 read value", {24'b0, flag_rdata}, {24'b0, exp_rd(m_flg, m_en)});
    @(posedge clk);
    #1;
    if (we) m_en = wd;
    m_flg = (re ? 3'b000 : m_flg) | {u, a, p};
    evt_per = 0; evt_alm = 0; evt_upd = 0; en_we = 0; flag_re = 0;
    @(negedge clk);
    chk_all("step");
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    #20;
    chk_all("reset R7");
    @(negedge clk); rst_n = 1'b1;

    // R1: flags set with enables off, irq stays floated
    step(1, 0, 0, 0, 4'h0, 0);
    chk("R1 periodic flag", {31'b0, flag_rdata[6]}, 32'd1);
    chk("R2 no irq w/o enable", {31'b0, irq_oe}, 32'd0);
    step(0, 1, 1, 0, 4'h0, 0);
    // R6: enable pending flag raises irq next cycle
    step(0, 0, 0, 1, 4'b0010, 0);
    chk("R6 irq after enable write", {31'b0, irq_oe}, 32'd1);
    // R4: read clears, releases irq
    step(0, 0, 0, 0, 4'h0, 1);
    chk("R4 flags cleared", {29'b0, flag_rdata[6:4]}, 32'd0);
    chk("R4 irq released", {31'b0, irq_oe}, 32'd0);
    // R5: event with read is kept
    step(0, 1, 0, 0, 4'h0, 0);
    step(0, 1, 0, 0, 4'h0, 1);
    chk("R5 alarm kept", {31'b0, flag_rdata[5]}, 32'd1);
    chk("R5 irq kept", {31'b0, irq_oe}, 32'd1);
    // R8: square wave enable
    step(0, 0, 0, 1, 4'b1111, 0);
    chk("R8 sqw set", {31'b0, sqw_en}, 32'd1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7] & r[8], r[12:9], r[13] & r[14]);
    end

    // R7: reset mid-run, asynchronous clear
    step(1, 1, 1, 1, 4'b1111, 0);
    @(negedge clk); #1 rst_n = 1'b0; #1;
    m_flg = 3'b0; m_en = 4'b0;
    chk_all("async R7");
    chk("R7 irq floated", {31'b0, irq_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 1, 4'b0100, 0);
    chk("R1 after reset", {31'b0, irq_oe}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule